// File: doc/BRIEF.md
# Audio Codec Control-Port Initialiser

This block powers up an audio codec and programs its serial control port by driving the pins directly. After system reset it holds the codec's active-low reset and active-low chip select low for a hold period. It then releases reset and writes a 32-bit control word twice. The codec discards the first write, and the second write loads the real settings. Each write is one chip-select window. Inside that window the upper half-word and then the lower half-word are shifted out, most significant bit first, on a slow bit-banged clock.

The control word is built from field inputs: output attenuation, mute, input selection, input gain, interrupt masking and a general-purpose output. The reserved bits are forced to zero. Once initialisation is done, a single-cycle update request starts one more write of the current field inputs. A busy flag shows when the port is occupied, and requests made while it is busy are dropped. The hold period and the half-period of the control clock are parameters counted in system clocks.

Top module: `codec_ctl_init`

## Requirements
- R1: While `rst` is high, `codec_rst_n` and `codec_cs_n` are low. After `rst` falls, `codec_rst_n` stays low for HOLD_CYCLES clocks (one extra clock is tolerated). It then rises and stays high until the next `rst`.
- R2: After the reset hold, exactly two complete writes of the control word take place without any request.
- R3: A write keeps `codec_cs_n` low for 32 control-clock pulses. The upper 16 bits go first, then the lower 16, each MSB first. `codec_cs_n` rises after the 32nd pulse. Between the two power-up writes it stays high for HALF_CYCLES clocks.
- R4: `codec_cclk` rises in the same cycle that `codec_dout` takes the new bit. The clock stays high for HALF_CYCLES clocks and then low for HALF_CYCLES clocks. `codec_dout` does not change while `codec_cclk` is high.
- R5: The word has this layout:
  - bit 31 is 0
  - bit 30 is `irq_mask`
  - bit 29 is `gp_out`
  - bits 28:24 are `att_l`
  - bits 23:19 are `att_r`
  - bit 18 is `mute`
  - bit 17 is `insel_l`
  - bit 16 is `insel_r`
  - bits 15:12 are `gain_l`
  - bits 11:8 are `gain_r`
  - bits 7:0 are 0
- R6: `busy` is high from reset until the second power-up write ends. It then goes low.
- R7: When `upd_req` is high while idle, the block makes exactly one write of the field inputs sampled in that cycle. `busy` is high during that write.
- R8: When `upd_req` is high while `busy` is high, it has no effect: no further write follows.
- R9: `codec_cclk` is low whenever `codec_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_req | input | 1 | Request one write of the current fields |
| irq_mask | input | 1 | Interrupt-pin mask field |
| gp_out | input | 1 | General-purpose output field |
| att_l | input | 5 | Left output attenuation, 1.5 dB steps |
| att_r | input | 5 | Right output attenuation, 1.5 dB steps |
| mute | input | 1 | Output mute field |
| insel_l | input | 1 | Left input select field |
| insel_r | input | 1 | Right input select field |
| gain_l | input | 4 | Left input gain, 1.5 dB steps |
| gain_r | input | 4 | Right input gain, 1.5 dB steps |
| codec_rst_n | output | 1 | Codec reset, active low |
| codec_cs_n | output | 1 | Control-port chip select, active low |
| codec_cclk | output | 1 | Control-port clock |
| codec_dout | output | 1 | Control-port serial data |
| busy | output | 1 | Port occupied; update requests are ignored |

## Verification
The bench builds the block with HOLD_CYCLES = 40 and HALF_CYCLES = 3 instead of the 50 ms default. This shrinks the reset hold to a length whose exact duration can be measured clock by clock, and keeps each 32-bit write near 200 clocks. With these values the whole power-up sequence, several update writes and a request issued in mid-write all fit in one short run. The odd half-period also makes an off-by-one in either clock phase or in the inter-write gap show up as a timing mismatch.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int HALF_BITS  = 16;
    localparam int NUM_HALVES = 2;
    localparam int FRAME_BITS = HALF_BITS * NUM_HALVES;

    // Setting fields, most significant first; they occupy word bits 30..8.
    typedef struct packed {
        logic       irq_mask;
        logic       gp_out;
        logic [4:0] att_l;
        logic [4:0] att_r;
        logic       mute;
        logic       insel_l;
        logic       insel_r;
        logic [3:0] gain_l;
        logic [3:0] gain_r;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_SEND,
        ST_GAP,
        ST_IDLE
    } seq_state_t;

    function automatic logic [FRAME_BITS-1:0] pack_ctl(input ctl_fields_t f);
        return {1'b0, f, 8'h00};
    endfunction

endpackage

// File: rtl/codec_ctl_timer.sv
module codec_ctl_timer #(
    parameter int          W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= INIT;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/codec_ctl_shifter.sv
module codec_ctl_shifter
    import codec_ctl_pkg::*;
#(
    parameter int HALF_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  sclk,
    output logic                  sdata,
    output logic                  active,
    output logic                  done
);
    localparam int CW = $clog2(HALF_CYCLES + 1);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] PHASE_LAST = CW'(HALF_CYCLES - 1);
    localparam logic [BW-1:0] BIT_LAST   = BW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [BW-1:0]         bit_idx_q;
    logic [CW-1:0]         cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q   <= '0;
            bit_idx_q <= '0;
            cnt_q     <= '0;
            sclk      <= 1'b0;
            sdata     <= 1'b0;
            active    <= 1'b0;
        end else if (start && !active) begin
            shreg_q   <= word;
            sdata     <= word[FRAME_BITS-1];
            sclk      <= 1'b1;
            cnt_q     <= PHASE_LAST;
            bit_idx_q <= '0;
            active    <= 1'b1;
        end else if (active) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (sclk) begin
                sclk  <= 1'b0;
                cnt_q <= PHASE_LAST;
            end else if (bit_idx_q == BIT_LAST) begin
                active <= 1'b0;
            end else begin
                shreg_q   <= shreg_q << 1;
                sdata     <= shreg_q[FRAME_BITS-2];
                sclk      <= 1'b1;
                cnt_q     <= PHASE_LAST;
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    assign done = active && !sclk && (cnt_q == '0) && (bit_idx_q == BIT_LAST);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // R9
    end_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> !sclk);

endmodule

// File: rtl/codec_ctl_init.sv
module codec_ctl_init
    import codec_ctl_pkg::*;
#(
    parameter int HOLD_CYCLES = 2500000,
    parameter int HALF_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_req,
    input  logic       irq_mask,
    input  logic       gp_out,
    input  logic [4:0] att_l,
    input  logic [4:0] att_r,
    input  logic       mute,
    input  logic       insel_l,
    input  logic       insel_r,
    input  logic [3:0] gain_l,
    input  logic [3:0] gain_r,
    output logic       codec_rst_n,
    output logic       codec_cs_n,
    output logic       codec_cclk,
    output logic       codec_dout,
    output logic       busy
);
    localparam int TMAX = (HOLD_CYCLES > HALF_CYCLES) ? HOLD_CYCLES : HALF_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HOLD_INIT = TW'(HOLD_CYCLES - 1);
    localparam logic [TW-1:0] GAP_LOAD  = TW'(HALF_CYCLES - 1);

    seq_state_t            state_q;
    ctl_fields_t           fields;
    logic [FRAME_BITS-1:0] word;
    logic                  second_q;
    logic                  rst_n_q, cs_n_q;
    logic                  start, tmr_load, tmr_exp;
    logic                  sh_active, sh_done;

    always_comb begin
        fields.irq_mask = irq_mask;
        fields.gp_out   = gp_out;
        fields.att_l    = att_l;
        fields.att_r    = att_r;
        fields.mute     = mute;
        fields.insel_l  = insel_l;
        fields.insel_r  = insel_r;
        fields.gain_l   = gain_l;
        fields.gain_r   = gain_r;
        word            = pack_ctl(fields);
    end

    always_comb begin
        start    = 1'b0;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_HOLD: start    = tmr_exp;
            ST_SEND: tmr_load = sh_done;
            ST_GAP:  start    = tmr_exp && second_q;
            ST_IDLE: start    = upd_req;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HOLD;
            rst_n_q  <= 1'b0;
            cs_n_q   <= 1'b0;
            second_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_HOLD: if (tmr_exp) begin
                    rst_n_q <= 1'b1;
                    state_q <= ST_SEND;
                end
                ST_SEND: if (sh_done) begin
                    cs_n_q  <= 1'b1;
                    state_q <= ST_GAP;
                end
                ST_GAP: if (tmr_exp) begin
                    if (second_q) begin
                        second_q <= 1'b0;
                        cs_n_q   <= 1'b0;
                        state_q  <= ST_SEND;
                    end else begin
                        state_q  <= ST_IDLE;
                    end
                end
                ST_IDLE: if (upd_req) begin
                    cs_n_q  <= 1'b0;
                    state_q <= ST_SEND;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    codec_ctl_timer #(
        .W    (TW),
        .INIT (HOLD_INIT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (GAP_LOAD),
        .expired  (tmr_exp)
    );

    codec_ctl_shifter #(
        .HALF_CYCLES (HALF_CYCLES)
    ) u_shifter (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .word   (word),
        .sclk   (codec_cclk),
        .sdata  (codec_dout),
        .active (sh_active),
        .done   (sh_done)
    );

    assign codec_rst_n = rst_n_q;
    assign codec_cs_n  = cs_n_q;
    assign busy        = (state_q != ST_IDLE);

    // R1
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        codec_rst_n |=> codec_rst_n);

    // R9
    desel_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        codec_cs_n |-> !codec_cclk);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (codec_cs_n && codec_rst_n && !sh_active));

    // R3
    shift_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        sh_active |-> !codec_cs_n);

endmodule

// File: tb/codec_ctl_init_test.sv
module codec_ctl_init_test;
    localparam int HOLD = 40;
    localparam int HALF = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, upd_req, irq_mask, gp_out, mute, insel_l, insel_r;
    logic [4:0] att_l, att_r;
    logic [3:0] gain_l, gain_r;
    logic codec_rst_n, codec_cs_n, codec_cclk, codec_dout, busy;

    codec_ctl_init #(.HOLD_CYCLES(HOLD), .HALF_CYCLES(HALF)) uut (
        .clk(clk), .rst(rst), .upd_req(upd_req), .irq_mask(irq_mask),
        .gp_out(gp_out), .att_l(att_l), .att_r(att_r), .mute(mute),
        .insel_l(insel_l), .insel_r(insel_r), .gain_l(gain_l), .gain_r(gain_r),
        .codec_rst_n(codec_rst_n), .codec_cs_n(codec_cs_n),
        .codec_cclk(codec_cclk), .codec_dout(codec_dout), .busy(busy)
    );

    int checks = 0, fails = 0, frames = 0;
    int tbad = 0, early_idle = 0, r9bad = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Word built from the R5 bit positions.
    function automatic logic [31:0] expect_word();
        return (32'(irq_mask) << 30) | (32'(gp_out) << 29) | (32'(att_l) << 24) |
               (32'(att_r) << 19) | (32'(mute) << 18) | (32'(insel_l) << 17) |
               (32'(insel_r) << 16) | (32'(gain_l) << 12) | (32'(gain_r) << 8);
    endfunction

    task automatic set_fields(input logic [22:0] v);
        {irq_mask, gp_out, att_l, att_r, mute, insel_l, insel_r, gain_l, gain_r} = v;
    endtask

    // Monitor: rebuilds each write from the pins and scores it.
    logic [31:0] sh;
    int nb, hi, lo, gap;
    logic prev_clk, prev_cs, prev_dout;
    always @(negedge clk) begin
        if (rst) begin
            sh = 0; nb = 0; hi = 0; lo = 0; gap = 0;
            prev_clk = 0; prev_cs = 0; prev_dout = 0;
        end else begin
            if (codec_cs_n && codec_cclk) r9bad++;
            if (!codec_cs_n && codec_cclk && !prev_clk) begin
                if (nb > 0 && lo != HALF) tbad++;
                sh = {sh[30:0], codec_dout};
                nb++;
                hi = 1;
            end else if (codec_cclk && prev_clk) begin
                hi++;
                if (codec_dout != prev_dout) tbad++;
            end
            if (!codec_cclk && prev_clk) begin
                if (hi != HALF) tbad++;
                lo = 1;
            end else if (!codec_cclk) begin
                lo++;
            end
            if (!busy && frames < 2) early_idle++;
            if (codec_cs_n && !prev_cs) begin
                frames++;
                chk(nb == 32, "R3", "pulses per write", 32'(nb), 32);
                chk(tbad == 0, "R4", "bit phase timing errors", 32'(tbad), 0);
                if (exp_q.size() == 0)
                    chk(0, "R8", "write with no pending request", sh, 0);
                else
                    chk(1, "R5", "", 0, 0) ;
                if (exp_q.size() != 0) begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(sh == e, "R5", "written word", sh, e);
                end
                sh = 0; nb = 0; tbad = 0; gap = 0;
            end
            if (codec_cs_n) gap++;
            if (!codec_cs_n && prev_cs) begin
                if (frames == 1) chk(gap == HALF, "R3", "gap between power-up writes", 32'(gap), 32'(HALF));
                gap = 0;
            end
            prev_clk = codec_cclk; prev_cs = codec_cs_n; prev_dout = codec_dout;
        end
    end

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, req, "busy returns low", 32'(busy), 0);
    endtask

    task automatic pulse_req();
        @(negedge clk) upd_req = 1'b1;
        @(negedge clk) upd_req = 1'b0;
    endtask

    task automatic do_update(input logic [22:0] v, input string req);
        int f0;
        set_fields(v);
        exp_q.push_back(expect_word());
        f0 = frames;
        pulse_req();
        chk(busy, "R7", "busy during update", 32'(busy), 1);
        wait_idle(req);
        repeat (5) @(negedge clk);
        chk(frames == f0 + 1, "R7", "one write per request", 32'(frames - f0), 1);
        chk(exp_q.size() == 0, req, "expected writes left", 32'(exp_q.size()), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        int lowcnt;
        int f0;
        rst = 1'b1; upd_req = 1'b0;
        set_fields(23'h2A5C3F);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!codec_rst_n && !codec_cs_n, "R1", "reset and select low in reset",
            {codec_rst_n, codec_cs_n}, 0);
        chk(busy && !codec_cclk, "R6", "busy high, clock low in reset", {busy, codec_cclk}, 2'b10);
        exp_q.push_back(expect_word());
        exp_q.push_back(expect_word());
        rst = 1'b0;
        lowcnt = 0;
        while (!codec_rst_n && lowcnt < HOLD + 10) begin
            lowcnt++;
            @(negedge clk);
        end
        chk(lowcnt >= HOLD && lowcnt <= HOLD + 1, "R1", "reset hold clocks", 32'(lowcnt), 32'(HOLD));
        chk(!codec_cs_n, "R3", "select still low at reset release", 32'(codec_cs_n), 0);
        wait_idle("R6");
        chk(frames == 2, "R2", "power-up writes", 32'(frames), 2);
        chk(early_idle == 0, "R6", "idle before second write", 32'(early_idle), 0);
        chk(exp_q.size() == 0, "R2", "power-up writes pending", 32'(exp_q.size()), 0);
        repeat (100) @(negedge clk);
        chk(frames == 2, "R7", "no write without request", 32'(frames), 2);

        // R5 field positions, one pattern each
        do_update(23'b0_0_11111_00000_0_0_0_0000_0000, "R5");
        do_update(23'b0_0_00000_11111_0_0_1_0000_1111, "R5");
        do_update(23'b1_1_00000_00000_1_1_0_1111_0000, "R5");
        do_update(23'h7FFFFF, "R5");

        // R8 request during an update is dropped
        set_fields(23'h123456);
        exp_q.push_back(expect_word());
        f0 = frames;
        pulse_req();
        repeat (50) @(negedge clk);
        set_fields(23'h654321);
        pulse_req();
        wait_idle("R8");
        repeat (300) @(negedge clk);
        chk(frames == f0 + 1, "R8", "writes after mid-write request", 32'(frames - f0), 1);
        chk(exp_q.size() == 0, "R8", "expected writes left", 32'(exp_q.size()), 0);
        chk(codec_rst_n, "R1", "reset stays released", 32'(codec_rst_n), 1);
        chk(r9bad == 0, "R9", "clock high while deselected", 32'(r9bad), 0);
        finish_run();
    end
endmodule